// File: doc/BRIEF.md
# Inter-core doorbell message unit

This block takes one doorbell command per cycle from any of `NCORE` cores and turns it into per-core pending doorbell state. A command names the issuing core, an operation, and a message word. The message word carries a type field, a broadcast flag and a target tag. The unit keeps three pending bits per core: ordinary doorbell, critical doorbell and hypervisor doorbell. It also raises a one-cycle interrupt request on every core whose pending state was set by a send.

There are three command families. Embedded-style commands map type 0 to the ordinary doorbell and type 1 to the critical doorbell. Sends from this family reach cores by tag match or by broadcast, and clears act only on the issuer. Guest types 2, 3 and 4, and every other type, are dropped. Server-style commands act only on type 5. They reach the hypervisor doorbell of the single tag-matched core, and the broadcast flag has no effect. Privileged same-core commands also require type 5 and set or clear the issuer's own ordinary doorbell. Each core's processor ID is a parameter.

Top module: `dbell_msg_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all pending bits and all interrupt requests read 0.
- R2: An embedded send (op 1) of type 0 sets `db_pend` on every core whose ID equals the tag, and one of type 1 sets `cdb_pend` on those cores. The type is in message bits [31:27], the broadcast flag is in bit 26, and the tag is in bits [25:0], compared with the ID zero-extended.
- R3: An embedded send with the broadcast flag set reaches every core, whatever the tag.
- R4: In the cycle after any send that sets a pending bit, `irq_req` is high for exactly the cores it set. In all other cycles `irq_req` is low.
- R5: Embedded send or clear with a type other than 0 or 1, including the guest types 2, 3 and 4, changes no pending bit and raises no request.
- R6: An embedded clear (op 2) of type 0 or 1 clears the matching bit on the issuing core only.
- R7: A server send (op 3) of type 5 sets `hdb_pend` on the core whose ID equals the tag. The broadcast flag is ignored.
- R8: A server clear (op 4) of type 5 clears the issuer's `hdb_pend`.
- R9: Server and privileged commands (ops 3 to 6) with a type other than 5 have no effect.
- R10: A privileged send (op 5) of type 5 sets the issuer's `db_pend`, and a privileged clear (op 6) of type 5 clears it. No other core is touched.
- R11: An update becomes visible on the clock edge that samples the command. With `cmd_valid` low, or with op 0 or 7, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation: 1 embedded send, 2 embedded clear, 3 server send, 4 server clear, 5 privileged send, 6 privileged clear |
| cmd_src | input | SRC_W | Index of the issuing core |
| cmd_msg | input | MSG_W | Message word: type, broadcast flag, tag |
| db_pend | output | NCORE | Ordinary doorbell pending, one bit per core |
| cdb_pend | output | NCORE | Critical doorbell pending, one bit per core |
| hdb_pend | output | NCORE | Hypervisor doorbell pending, one bit per core |
| irq_req | output | NCORE | One-cycle interrupt request, one bit per core |

## Verification
Every result has a latency of one edge. The pending bits and `irq_req` both come from flops that load on the edge that samples the command, so both are due one cycle after the command is applied. The bench drives each command on a falling edge and compares all four output vectors at the next falling edge. It does this against a model that it updates once per command. Commands are issued back to back, so each `irq_req` pulse has to drop again in the following check, unless another send sets it.

// File: rtl/dbmu_pkg.sv
package dbmu_pkg;
  localparam logic [2:0] OP_ESEND = 3'd1;
  localparam logic [2:0] OP_ECLR  = 3'd2;
  localparam logic [2:0] OP_SSEND = 3'd3;
  localparam logic [2:0] OP_SCLR  = 3'd4;
  localparam logic [2:0] OP_PSEND = 3'd5;
  localparam logic [2:0] OP_PCLR  = 3'd6;

  localparam int          TYPE_W  = 5;
  localparam logic [4:0]  T_NORM  = 5'd0;
  localparam logic [4:0]  T_CRIT  = 5'd1;
  localparam logic [4:0]  T_SRV   = 5'd5;

  typedef struct packed {
    logic db_set;
    logic db_clr;
    logic cdb_set;
    logic cdb_clr;
    logic hdb_set;
    logic hdb_clr;
  } slot_upd_t;
endpackage

// File: rtl/dbmu_decode.sv
module dbmu_decode
  import dbmu_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int ID_W  = 8,
  parameter int MSG_W = 32,
  parameter int SRC_W = 2,
  parameter logic [NCORE*ID_W-1:0] CORE_IDS = '0
) (
  input  logic                        valid,
  input  logic [2:0]                  op,
  input  logic [SRC_W-1:0]            src,
  input  logic [MSG_W-1:0]            msg,
  output slot_upd_t [NCORE-1:0]       upd
);
  localparam int BC_POS = MSG_W - TYPE_W - 1;
  localparam int TAG_W  = BC_POS;

  logic [TYPE_W-1:0] typ;
  logic              bcast;
  logic [TAG_W-1:0]  tag;

  assign typ   = msg[MSG_W-1 -: TYPE_W];
  assign bcast = msg[BC_POS];
  assign tag   = msg[TAG_W-1:0];

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic hit, mine;
    assign hit  = (tag == TAG_W'(CORE_IDS[i*ID_W +: ID_W]));
    assign mine = (src == SRC_W'(i));

    always_comb begin
      upd[i] = '0;
      if (valid) begin
        case (op)
          OP_ESEND: begin
            if (typ == T_NORM) upd[i].db_set  = hit | bcast;
            if (typ == T_CRIT) upd[i].cdb_set = hit | bcast;
          end
          OP_ECLR: begin
            if (typ == T_NORM) upd[i].db_clr  = mine;
            if (typ == T_CRIT) upd[i].cdb_clr = mine;
          end
          OP_SSEND: if (typ == T_SRV) upd[i].hdb_set = hit;
          OP_SCLR:  if (typ == T_SRV) upd[i].hdb_clr = mine;
          OP_PSEND: if (typ == T_SRV) upd[i].db_set  = mine;
          OP_PCLR:  if (typ == T_SRV) upd[i].db_clr  = mine;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbmu_slot.sv
module dbmu_slot
  import dbmu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_upd_t upd,
  output logic      db,
  output logic      cdb,
  output logic      hdb,
  output logic      irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      db  <= 1'b0;
      cdb <= 1'b0;
      hdb <= 1'b0;
      irq <= 1'b0;
    end else begin
      db  <= (db  & ~upd.db_clr)  | upd.db_set;
      cdb <= (cdb & ~upd.cdb_clr) | upd.cdb_set;
      hdb <= (hdb & ~upd.hdb_clr) | upd.hdb_set;
      irq <= upd.db_set | upd.cdb_set | upd.hdb_set;
    end
  end
endmodule

// File: rtl/dbell_msg_unit.sv
module dbell_msg_unit
  import dbmu_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int ID_W  = 8,
  parameter int MSG_W = 32,
  parameter logic [NCORE*ID_W-1:0] CORE_IDS = {8'h23, 8'h22, 8'h21, 8'h20},
  localparam int SRC_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [SRC_W-1:0] cmd_src,
  input  logic [MSG_W-1:0] cmd_msg,
  output logic [NCORE-1:0] db_pend,
  output logic [NCORE-1:0] cdb_pend,
  output logic [NCORE-1:0] hdb_pend,
  output logic [NCORE-1:0] irq_req
);
  slot_upd_t [NCORE-1:0] upd;

  dbmu_decode #(
    .NCORE(NCORE), .ID_W(ID_W), .MSG_W(MSG_W), .SRC_W(SRC_W), .CORE_IDS(CORE_IDS)
  ) u_dec (
    .valid(cmd_valid), .op(cmd_op), .src(cmd_src), .msg(cmd_msg), .upd(upd)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_slot
    dbmu_slot u_slot (
      .clk(clk), .rst(rst), .upd(upd[i]),
      .db(db_pend[i]), .cdb(cdb_pend[i]), .hdb(hdb_pend[i]), .irq(irq_req[i])
    );
  end
endmodule

// File: rtl/dbmu_chk.sv
module dbmu_chk
  import dbmu_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int MSG_W = 32,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [SRC_W-1:0] cmd_src,
  input logic [MSG_W-1:0] cmd_msg,
  input logic [NCORE-1:0] db_pend,
  input logic [NCORE-1:0] cdb_pend,
  input logic [NCORE-1:0] hdb_pend,
  input logic [NCORE-1:0] irq_req
);
  logic [4:0] typ;
  logic       is_send, is_emb, is_srv, run;
  assign typ     = cmd_msg[MSG_W-1 -: 5];
  assign run     = cmd_valid && (cmd_op != 3'd0) && (cmd_op != 3'd7);
  assign is_send = cmd_op == OP_ESEND || cmd_op == OP_SSEND || cmd_op == OP_PSEND;
  assign is_emb  = cmd_op == OP_ESEND || cmd_op == OP_ECLR;
  assign is_srv  = !is_emb && run;

  AST_EMB_BADTYPE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_emb && typ != T_NORM && typ != T_CRIT)
      |=> ($stable({db_pend, cdb_pend, hdb_pend}) && irq_req == '0)); // R5

  AST_SRV_BADTYPE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (is_srv && typ != T_SRV)
      |=> ($stable({db_pend, cdb_pend, hdb_pend}) && irq_req == '0)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> ($stable({db_pend, cdb_pend, hdb_pend}) && irq_req == '0)); // R11

  AST_ECLR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ECLR)
      |=> (((db_pend & ~$past(db_pend)) == '0) && ((cdb_pend & ~$past(cdb_pend)) == '0)
           && $stable(hdb_pend))); // R6

  AST_IRQ_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> $past(cmd_valid && is_send)); // R4

  AST_HDB_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    ((hdb_pend & ~$past(hdb_pend)) != '0) |->
      $past(cmd_valid && cmd_op == OP_SSEND && typ == T_SRV)); // R7

  AST_HDB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ($countones(hdb_pend & ~$past(hdb_pend)) <= 1)); // R7

  AST_DB_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    ((db_pend & ~$past(db_pend)) != '0) |->
      $past(cmd_valid && (cmd_op == OP_ESEND || cmd_op == OP_PSEND))); // R2

  AST_PSEND_ONE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PSEND) |=> ($onehot0(irq_req) && $stable({cdb_pend, hdb_pend}))); // R10
endmodule

bind dbell_msg_unit dbmu_chk #(.NCORE(NCORE), .MSG_W(MSG_W), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/sim_dbell_msg_unit.sv
`timescale 1ns/1ps
module sim_dbell_msg_unit;
  localparam int NCORE = 4;
  localparam int ID_W  = 8;
  localparam int MSG_W = 32;
  localparam int SRC_W = 2;
  localparam logic [NCORE*ID_W-1:0] IDS = {8'h23, 8'h22, 8'h21, 8'h20};

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [SRC_W-1:0] cmd_src = '0;
  logic [MSG_W-1:0] cmd_msg = '0;
  logic [NCORE-1:0] db_pend, cdb_pend, hdb_pend, irq_req;

  logic [NCORE-1:0] e_db = '0, e_cdb = '0, e_hdb = '0, e_irq = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbell_msg_unit #(.NCORE(NCORE), .ID_W(ID_W), .MSG_W(MSG_W), .CORE_IDS(IDS)) u0 (.*);

  function automatic logic [MSG_W-1:0] mk(input logic [4:0] t, input logic b, input logic [25:0] tg);
    return {t, b, tg};
  endfunction

  task automatic check(input string req, input string what, input logic [NCORE-1:0] act, input logic [NCORE-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "db_pend", db_pend, e_db);
    check(req, "cdb_pend", cdb_pend, e_cdb);
    check(req, "hdb_pend", hdb_pend, e_hdb);
    check(req, "irq_req", irq_req, e_irq);
  endtask

  task automatic model(input logic v, input logic [2:0] op, input logic [SRC_W-1:0] src, input logic [MSG_W-1:0] m);
    logic [4:0] t;
    logic bc;
    logic [25:0] tg;
    t = m[31:27]; bc = m[26]; tg = m[25:0];
    e_irq = '0;
    if (!v) return;
    for (int i = 0; i < NCORE; i++) begin
      logic hit, me;
      hit = (tg == 26'(IDS[i*ID_W +: ID_W]));
      me  = (src == SRC_W'(i));
      case (op)
        3'd1: begin
          if (t == 5'd0 && (hit || bc)) begin e_db[i] = 1'b1;  e_irq[i] = 1'b1; end
          if (t == 5'd1 && (hit || bc)) begin e_cdb[i] = 1'b1; e_irq[i] = 1'b1; end
        end
        3'd2: begin
          if (t == 5'd0 && me) e_db[i] = 1'b0;
          if (t == 5'd1 && me) e_cdb[i] = 1'b0;
        end
        3'd3: if (t == 5'd5 && hit) begin e_hdb[i] = 1'b1; e_irq[i] = 1'b1; end
        3'd4: if (t == 5'd5 && me) e_hdb[i] = 1'b0;
        3'd5: if (t == 5'd5 && me) begin e_db[i] = 1'b1; e_irq[i] = 1'b1; end
        3'd6: if (t == 5'd5 && me) e_db[i] = 1'b0;
        default: ;
      endcase
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic cmd(input logic v, input logic [2:0] op, input logic [SRC_W-1:0] src,
                     input logic [MSG_W-1:0] m, input string req);
    cmd_valid = v; cmd_op = op; cmd_src = src; cmd_msg = m;
    model(v, op, src, m);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 after reset");

    cmd(1, 3'd1, 2'd0, mk(5'd0, 1'b0, 26'h21), "R2 R4 normal send tag");
    cmd(1, 3'd1, 2'd0, mk(5'd1, 1'b0, 26'h23), "R2 critical send tag");
    cmd(1, 3'd1, 2'd0, mk(5'd0, 1'b0, 26'h45), "R2 tag miss");
    cmd(1, 3'd1, 2'd1, mk(5'd0, 1'b1, 26'h99), "R3 broadcast");
    cmd(1, 3'd1, 2'd1, mk(5'd2, 1'b1, 26'h20), "R5 guest type 2");
    cmd(1, 3'd1, 2'd1, mk(5'd3, 1'b1, 26'h20), "R5 guest type 3");
    cmd(1, 3'd2, 2'd3, mk(5'd4, 1'b0, 26'h0),  "R5 guest clear");
    cmd(1, 3'd2, 2'd2, mk(5'd0, 1'b0, 26'h20), "R6 embedded clear issuer");
    cmd(1, 3'd2, 2'd3, mk(5'd1, 1'b0, 26'h0),  "R6 critical clear issuer");
    cmd(1, 3'd3, 2'd1, mk(5'd5, 1'b1, 26'h20), "R7 server send bcast ignored");
    cmd(1, 3'd3, 2'd1, mk(5'd0, 1'b0, 26'h21), "R9 server bad type");
    cmd(1, 3'd4, 2'd0, mk(5'd5, 1'b0, 26'h0),  "R8 server clear");
    cmd(1, 3'd5, 2'd2, mk(5'd5, 1'b0, 26'h0),  "R10 privileged send");
    cmd(1, 3'd6, 2'd1, mk(5'd5, 1'b0, 26'h0),  "R10 privileged clear");
    cmd(1, 3'd6, 2'd2, mk(5'd1, 1'b0, 26'h0),  "R9 privileged bad type");
    cmd(0, 3'd1, 2'd0, mk(5'd0, 1'b1, 26'h0),  "R11 valid low");
    cmd(1, 3'd7, 2'd0, mk(5'd5, 1'b1, 26'h20), "R11 op 7");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] t;
      logic [25:0] tg;
      logic [2:0] op;
      case ($urandom % 4)
        0: t = 5'd0;
        1: t = 5'd1;
        2: t = 5'd5;
        default: t = 5'($urandom);
      endcase
      tg = ($urandom % 4 != 0) ? 26'(8'h20 + ($urandom % 4)) : 26'($urandom);
      op = 3'($urandom);
      cmd(($urandom % 8) != 0, op, SRC_W'($urandom), mk(t, 1'($urandom), tg),
          (op == 3'd1) ? "R2 R3 R4 random" : (op == 3'd2) ? "R6 random" :
          (op == 3'd3) ? "R7 random" : (op == 3'd4) ? "R8 random" :
          (op == 3'd5 || op == 3'd6) ? "R10 random" : "R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule